// File: doc/BRIEF.md
# Dual-Mode Fault History Log

This block keeps a short history of faults for a host that reads it like a small buffer memory. It holds eight records, and each record is five 16-bit words: an error code, a length word, and three detail words. A one-cycle pulse on `log_valid` enters a new record. Record 1 always holds the most recent entry. A synchronous `clr` pulse erases the whole history. The host reads any word through `rd_addr`, which is a relative word address equal to record index times five plus the word offset. The read path is combinational: `rd_data` reflects `rd_addr` in the same cycle, with zero cycles of latency.

The `mode_fixed` input chooses how the log behaves once it is full.

- **Ring mode** (`mode_fixed`=0): the records keep sliding toward record 8, and the oldest one falls out.
- **Fixed mode** (`mode_fixed`=1): once eight records have been stored, records 2 to 8 are frozen. Every later fault only overwrites record 1.

Before the log is full, both modes fill it in the same way.

A small controller tracks how full the log is. It has three states:

- **EMPTY**: no records are stored.
- **FILLING**: between one and seven records are stored.
- **FULL**: eight records are stored.

Its transitions are:

- **T_FIRST**: from EMPTY to FILLING on a log pulse.
- **T_LAST**: from FILLING to FULL when a log pulse stores the eighth record.
- **T_CLEAR**: from any state to EMPTY on `clr`.
- **T_STAY**: any other cycle keeps the current state.

For each accepted pulse, the controller decides between two actions. It issues a *shift* (every record moves down, and the new record enters record 1) or a *head write* (only record 1 is replaced). A head write happens only in the FULL state with fixed mode selected.

Top module: `fhl_top`

## Requirements
- R1: The log has eight records of five words. Word `off` of record `k` (k=1..8, off 0=code, 1=length, 2..4=detail 1..3) reads at `rd_addr` = (k-1)*5+off, combinationally in the same cycle. Addresses 40 to 63 read as zero.
- R2: The length word stores `log_len` (0 to 3) in bits 1:0, with the upper bits zero. Detail word n is stored only when n <= `log_len`; otherwise it is stored as zero.
- R3: Every accepted log pulse places the new record in record 1 (addresses 0 to 4).
- R4: In ring mode, an accepted pulse moves records 1..7 to records 2..8. The previous record 8 is discarded.
- R5: In fixed mode, while fewer than eight records are stored, the log fills exactly as in ring mode. Once eight are stored, records 2 to 8 stay unchanged and each pulse overwrites only record 1.
- R6: A `clr` pulse sets every word to zero and resets the fill count in either mode. After a clear, fixed mode fills again before freezing.
- R7: When `clr` and `log_valid` are high in the same cycle, the clear wins and the record is dropped, so every word reads zero.
- R8: With neither `log_valid` nor `clr` high, the stored words do not change, whatever `mode_fixed` and `rd_addr` do.
- R9: A change of `mode_fixed` rearranges no stored record. It only decides how the next accepted pulse is applied.
- R10: After reset, all 64 addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_valid | input | 1 | One-cycle pulse that enters a record |
| log_code | input | 16 | Error code of the new record |
| log_len | input | 2 | Number of meaningful detail words (0 to 3) |
| log_d1 | input | 16 | Detail word 1 |
| log_d2 | input | 16 | Detail word 2 |
| log_d3 | input | 16 | Detail word 3 |
| mode_fixed | input | 1 | 1 = fixed mode, 0 = ring mode |
| clr | input | 1 | Synchronous clear of all records |
| rd_addr | input | 6 | Relative word address |
| rd_data | output | 16 | Word at `rd_addr`, combinational |

## Verification
The bench builds the block with its default parameters: eight records of 16-bit words and a 6-bit address. With these values the whole 64-address space can be swept after every operation, including the out-of-range addresses 40 to 63. Logging ten or more records reaches the FULL state, so both the fixed-mode freeze and the ring-mode discard come within a short run. Random mixes of logging, clearing and mode changes put the mode switch at every fill level, including the switch between ring and fixed while the log is full.

// File: rtl/fhl_pkg.sv
package fhl_pkg;
    localparam int FHL_WORDS = 5;     // words per record
    localparam int FHL_OFF_CODE = 0;
    localparam int FHL_OFF_LEN  = 1;
    localparam int FHL_OFF_DET  = 2;  // first detail word

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FILLING = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_e;
endpackage

// File: rtl/fhl_ctrl.sv
module fhl_ctrl
    import fhl_pkg::*;
#(
    parameter int NREC = 8,
    localparam int CW = $clog2(NREC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          log_valid,
    input  logic          clr,
    input  logic          mode_fixed,
    output logic          do_shift,
    output logic          do_head,
    output logic          do_clear,
    output logic [CW-1:0] fill_cnt
);
    fill_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          accept;

    assign accept = log_valid && !clr;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr) begin
            state_d = ST_EMPTY;          // T_CLEAR
            cnt_d   = '0;
        end else if (log_valid) begin
            unique case (state_q)
                ST_EMPTY: begin          // T_FIRST
                    cnt_d   = CW'(1);
                    state_d = (NREC == 1) ? ST_FULL : ST_FILLING;
                end
                ST_FILLING: begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == CW'(NREC - 1)) begin
                        state_d = ST_FULL; // T_LAST
                    end
                end
                ST_FULL: begin           // T_STAY
                    cnt_d = cnt_q;
                end
                default: begin
                    state_d = ST_EMPTY;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        do_shift = 1'b0;
        do_head  = 1'b0;
        do_clear = clr;
        unique case (state_q)
            ST_EMPTY, ST_FILLING: do_shift = accept;
            ST_FULL: begin
                do_shift = accept && !mode_fixed;
                do_head  = accept &&  mode_fixed;
            end
            default: ;
        endcase
    end

    assign fill_cnt = cnt_q;
endmodule

// File: rtl/fhl_store.sv
module fhl_store
    import fhl_pkg::*;
#(
    parameter int NREC = 8,
    parameter int DW   = 16,
    parameter int LW   = 2,
    localparam int TOT = NREC * FHL_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_shift,
    input  logic              do_head,
    input  logic              do_clear,
    input  logic [DW-1:0]     in_code,
    input  logic [LW-1:0]     in_len,
    input  logic [DW-1:0]     in_d1,
    input  logic [DW-1:0]     in_d2,
    input  logic [DW-1:0]     in_d3,
    output logic [TOT*DW-1:0] mem_flat
);
    logic [DW-1:0] mem_q [NREC][FHL_WORDS];
    logic [DW-1:0] new_w [FHL_WORDS];

    // build the incoming record, zeroing detail words past the length
    always_comb begin
        new_w[FHL_OFF_CODE]    = in_code;
        new_w[FHL_OFF_LEN]     = DW'(in_len);
        new_w[FHL_OFF_DET]     = (in_len >= LW'(1)) ? in_d1 : '0;
        new_w[FHL_OFF_DET + 1] = (in_len >= LW'(2)) ? in_d2 : '0;
        new_w[FHL_OFF_DET + 2] = (in_len >= LW'(3)) ? in_d3 : '0;
    end

    for (genvar r = 0; r < NREC; r++) begin : g_rec
        for (genvar w = 0; w < FHL_WORDS; w++) begin : g_word
            if (r == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        mem_q[r][w] <= '0;
                    end else if (do_clear) begin
                        mem_q[r][w] <= '0;
                    end else if (do_shift || do_head) begin
                        mem_q[r][w] <= new_w[w];
                    end
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        mem_q[r][w] <= '0;
                    end else if (do_clear) begin
                        mem_q[r][w] <= '0;
                    end else if (do_shift) begin
                        mem_q[r][w] <= mem_q[r-1][w];
                    end
                end
            end
            assign mem_flat[(r*FHL_WORDS + w)*DW +: DW] = mem_q[r][w];
        end
    end
endmodule

// File: rtl/fhl_rdport.sv
module fhl_rdport
    import fhl_pkg::*;
#(
    parameter int NREC = 8,
    parameter int DW   = 16,
    localparam int TOT = NREC * FHL_WORDS,
    localparam int AW  = $clog2(TOT)
) (
    input  logic [TOT*DW-1:0] mem_flat,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data
);
    always_comb begin
        rd_data = '0;
        for (int a = 0; a < TOT; a++) begin
            if (rd_addr == AW'(a)) begin
                rd_data = mem_flat[a*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/fhl_top.sv
module fhl_top
    import fhl_pkg::*;
#(
    parameter int NREC = 8,
    parameter int DW   = 16,
    parameter int LW   = 2,
    localparam int TOT = NREC * FHL_WORDS,
    localparam int AW  = $clog2(TOT),
    localparam int CW  = $clog2(NREC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          log_valid,
    input  logic [DW-1:0] log_code,
    input  logic [LW-1:0] log_len,
    input  logic [DW-1:0] log_d1,
    input  logic [DW-1:0] log_d2,
    input  logic [DW-1:0] log_d3,
    input  logic          mode_fixed,
    input  logic          clr,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic              do_shift, do_head, do_clear;
    logic [CW-1:0]     fill_cnt;
    logic [TOT*DW-1:0] mem_flat;

    fhl_ctrl #(.NREC(NREC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .log_valid  (log_valid),
        .clr        (clr),
        .mode_fixed (mode_fixed),
        .do_shift   (do_shift),
        .do_head    (do_head),
        .do_clear   (do_clear),
        .fill_cnt   (fill_cnt)
    );

    fhl_store #(.NREC(NREC), .DW(DW), .LW(LW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_shift (do_shift),
        .do_head  (do_head),
        .do_clear (do_clear),
        .in_code  (log_code),
        .in_len   (log_len),
        .in_d1    (log_d1),
        .in_d2    (log_d2),
        .in_d3    (log_d3),
        .mem_flat (mem_flat)
    );

    fhl_rdport #(.NREC(NREC), .DW(DW)) u_rd (
        .mem_flat (mem_flat),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/fhl_chk.sv
module fhl_chk
    import fhl_pkg::*;
#(
    parameter int NREC = 8,
    parameter int DW   = 16,
    localparam int TOT = NREC * FHL_WORDS,
    localparam int CW  = $clog2(NREC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              log_valid,
    input logic              clr,
    input logic              mode_fixed,
    input logic [DW-1:0]     log_code,
    input logic [CW-1:0]     fill_cnt,
    input logic [TOT*DW-1:0] mem_flat
);
    localparam int RW = FHL_WORDS * DW;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(NREC)); // R5

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fill_cnt == '0 && mem_flat == '0)); // R6

    AST_HEAD_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !clr) |=> mem_flat[DW-1:0] == $past(log_code)); // R3

    AST_RING_SLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !clr && !mode_fixed)
        |=> mem_flat[2*RW-1:RW] == $past(mem_flat[RW-1:0])); // R4

    AST_FIXED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !clr && mode_fixed && fill_cnt == CW'(NREC))
        |=> $stable(mem_flat[TOT*DW-1:RW])); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!log_valid && !clr) |=> $stable(mem_flat)); // R8

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_flat[2*DW-1:DW] <= DW'(3)); // R2

    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_flat[2*DW-1:DW] < DW'(3)) |-> mem_flat[5*DW-1:4*DW] == '0); // R2
endmodule

bind fhl_top fhl_chk #(.NREC(NREC), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .log_valid  (log_valid),
    .clr        (clr),
    .mode_fixed (mode_fixed),
    .log_code   (log_code),
    .fill_cnt   (fill_cnt),
    .mem_flat   (mem_flat)
);

// File: tb/tb_fhl_top.sv
`timescale 1ns/1ps
module tb_fhl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        log_valid = 1'b0;
    logic [15:0] log_code = '0;
    logic [1:0]  log_len = '0;
    logic [15:0] log_d1 = '0, log_d2 = '0, log_d3 = '0;
    logic        mode_fixed = 1'b0;
    logic        clr = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_mem [40];
    int m_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    fhl_top dut (
        .clk(clk), .rst_n(rst_n), .log_valid(log_valid), .log_code(log_code),
        .log_len(log_len), .log_d1(log_d1), .log_d2(log_d2), .log_d3(log_d3),
        .mode_fixed(mode_fixed), .clr(clr), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [15:0] det_word(input logic [1:0] len, input int n,
                                             input logic [15:0] v);
        return (int'(len) >= n) ? v : 16'h0;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < 40; i++) exp_mem[i] = '0;
        m_cnt = 0;
    endfunction

    function automatic void model_log(input logic fx, input logic [15:0] c,
        input logic [1:0] l, input logic [15:0] a, input logic [15:0] b,
        input logic [15:0] d);
        if (!(fx && m_cnt == 8)) begin
            for (int i = 39; i >= 5; i--) exp_mem[i] = exp_mem[i-5];
        end
        exp_mem[0] = c;
        exp_mem[1] = {14'h0, l};
        exp_mem[2] = det_word(l, 1, a);
        exp_mem[3] = det_word(l, 2, b);
        exp_mem[4] = det_word(l, 3, d);
        if (m_cnt < 8) m_cnt++;
    endfunction

    // sweep all 64 addresses while inputs are idle
    task automatic sweep(input string tag);
        for (int a = 0; a < 64; a++) begin
            logic [15:0] e;
            rd_addr = 6'(a);
            #0.1;
            e = (a < 40) ? exp_mem[a] : 16'h0;
            n_chk++;
            if (rd_data !== e) begin
                n_bad++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, e);
            end
        end
    endtask

    task automatic do_log(input logic [15:0] c, input logic [1:0] l,
        input logic [15:0] a, input logic [15:0] b, input logic [15:0] d,
        input logic with_clr);
        @(negedge clk);
        log_valid = 1'b1; log_code = c; log_len = l;
        log_d1 = a; log_d2 = b; log_d3 = d; clr = with_clr;
        @(posedge clk); #1;
        log_valid = 1'b0; clr = 1'b0;
        if (with_clr) model_clear();
        else model_log(mode_fixed, c, l, a, b, d);
    endtask

    task automatic do_clr();
        @(negedge clk); clr = 1'b1;
        @(posedge clk); #1; clr = 1'b0;
        model_clear();
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0041));
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        sweep("R10 reset");

        // R1 R2 addressing and masking, each length
        for (int l = 0; l < 4; l++) begin
            do_log(16'hC000 + 16'(l), 2'(l), 16'h1111, 16'h2222, 16'h3333, 1'b0);
            sweep("R2 length mask");
        end
        sweep("R1 layout");

        // R5 fixed mode fills, then freezes
        do_clr(); sweep("R6 clear");
        mode_fixed = 1'b1;
        for (int i = 0; i < 11; i++) begin
            do_log(16'hF000 + 16'(i), 2'd3, 16'(i), 16'(i+1), 16'(i+2), 1'b0);
            sweep("R5 fixed freeze");
        end

        // R9 mode change alone rearranges nothing, R8 idle hold
        mode_fixed = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); sweep("R9 mode change");
        // R4 ring slide, oldest discarded
        for (int i = 0; i < 3; i++) begin
            do_log(16'hA000 + 16'(i), 2'd1, 16'hBEEF, 16'h0, 16'h0, 1'b0);
            sweep("R4 ring slide");
        end

        // R7 clear beats log
        do_log(16'hDEAD, 2'd3, 16'h1, 16'h2, 16'h3, 1'b1);
        sweep("R7 clear priority");

        // R6 fixed mode refills after a clear
        mode_fixed = 1'b1;
        for (int i = 0; i < 9; i++) do_log(16'h7700 + 16'(i), 2'd2, 16'h5, 16'h6, 16'h7, 1'b0);
        do_clr();
        for (int i = 0; i < 3; i++) do_log(16'h6600 + 16'(i), 2'd0, 16'h9, 16'h9, 16'h9, 1'b0);
        sweep("R6 refill");

        // random mix of log, clear, mode change, idle
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom_range(0, 19));
            if (op < 12) begin
                do_log(16'($urandom), 2'($urandom), 16'($urandom), 16'($urandom),
                       16'($urandom), (op == 0));
            end else if (op < 13) begin
                do_clr();
            end else if (op < 17) begin
                @(negedge clk); mode_fixed = ~mode_fixed;
            end else begin
                @(negedge clk); rd_addr = 6'($urandom);
            end
            @(negedge clk);
            sweep("R3 R4 R5 R8 R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule